// File: doc/BRIEF.md
# Fault and Power-State Supervisor

This block decides, every clock cycle, whether a stepper driver's two H-bridges may conduct and whether the step indexer may accept a STEP pulse. It takes in raw flags from the analog protection circuits: a supply-low flag, a die-hot flag and one overcurrent flag per bridge. It also takes the three active-low control pins for sleep, reset and enable. All of these inputs are asynchronous, so each one passes through a synchronizer before any decision is made.

The fault classes behave differently. An overcurrent flag must stay high for a programmable qualification window. Once it does, the block latches a shutdown that only a reset pulse or a power cycle removes. The thermal flag shuts the bridges and clears by itself. A supply-low condition blanks the whole block and wipes its state. Leaving sleep starts a settling timer, and steps are refused until that timer has run out.

The block produces four outputs. A global bridge-disable stops the bridges. An indexer reset puts the step table back to home. An active-low fault output reports overcurrent and thermal faults only. A step qualifier tells the indexer when STEP edges may be honoured. The indexer and the drivers use these outputs directly as plain level signals, with no handshake.

Top module: `power_fault_supervisor`

## Requirements
- R1: After `por_n` is released, `fault_n` is 1, `bridge_off` is 1 and `step_ok` is 0. The settling delay of R8 also runs from power-up, counted from the moment the synchronized inputs show the block awake.
- R2: An overcurrent flag latches a shutdown only when its synchronized value is high for `OC_QUAL` consecutive cycles. A pulse of `OC_QUAL-1` cycles or shorter leaves `fault_n` at 1. A flag raised just after a falling clock edge pulls `fault_n` low exactly `SYNC_STAGES+OC_QUAL` rising edges later.
- R3: A latched overcurrent holds `fault_n` at 0, `bridge_off` at 1 and `step_ok` at 0 after the flag has dropped again.
- R4: The overcurrent latch is cleared by a synchronized `reset_n` low while the block is awake, or by supply-low. Sleep does not clear it, and the fault reappears once sleep ends.
- R5: While the synchronized thermal flag is high (awake, supply good), `fault_n` is 0 and `bridge_off` is 1. Both return to normal by themselves `SYNC_STAGES` cycles after the flag clears.
- R6: While synchronized supply-low is high, `bridge_off` and `indexer_rst` are 1, `step_ok` is 0 and `fault_n` is 1 whatever the other inputs do. Supply-low clears the overcurrent latch and restarts the settling delay.
- R7: While the synchronized `sleep_n` is 0 and supply is good, `bridge_off` is 1, `step_ok` is 0, `fault_n` is 1 and `indexer_rst` is 0. In this state `reset_n`, `enable_n` and the overcurrent flags have no effect.
- R8: After the synchronized `sleep_n` rises, `step_ok` stays 0 for `WAKE_CYCLES` cycles. With `sleep_n` raised just after a falling edge, `step_ok` is 0 after `SYNC_STAGES+WAKE_CYCLES-1` rising edges and 1 after `SYNC_STAGES+WAKE_CYCLES`, provided no other condition blocks it.
- R9: `enable_n` high sets `bridge_off` to 1 and `step_ok` to 0. It leaves `indexer_rst` and `fault_n` unchanged.
- R10: A synchronized `reset_n` low while awake sets `indexer_rst` and `bridge_off` to 1 and `step_ok` to 0.
- R11: Asserting `reset_n` during supply-low does not end the supply-low state. `indexer_rst` and `bridge_off` stay 1 until the supply flag itself clears.
- R12: Every input acts through `SYNC_STAGES` flip-flops, and outputs follow the synchronized values with no further register. A change driven after a falling edge is not yet visible after `SYNC_STAGES-1` rising edges and is visible after `SYNC_STAGES`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Asynchronous active-low power-on reset; models supply removal and return |
| uv_flag | input | 1 | Supply-low indication, high while supply is below threshold |
| hot_flag | input | 1 | Die overtemperature indication, high while hot |
| oc_flag | input | NUM_BRIDGES | Per-bridge overcurrent indication, high while limiting |
| sleep_n | input | 1 | Active-low sleep request |
| reset_n | input | 1 | Active-low logic reset request |
| enable_n | input | 1 | Active-low output enable |
| bridge_off | output | 1 | High when all bridge switches must be off |
| indexer_rst | output | 1 | High while the indexer must return to its home state |
| fault_n | output | 1 | Low while an overcurrent latch or thermal fault is reported |
| step_ok | output | 1 | High when STEP edges may be honoured |

## Verification
The hardest situation to reach from the ports is a retained overcurrent latch that survives sleep. Getting there needs a qualified fault, then sleep. During sleep the bench pulses reset, enable and overcurrent, all of which must be ignored, and after wake the latched fault must reappear. The bench builds this in steps: it sweeps pulse lengths up to the qualification window, latches on the second bridge, and enters sleep before applying the ignored stimuli. It also times the exact latch edge and the settling delay at their boundary cycles. Finally, it overlaps supply-low with a latched fault, heat and a reset pulse to confirm the priority order.

// File: rtl/pfs_pkg.sv
package pfs_pkg;

  typedef enum logic [2:0] {
    SV_RUN    = 3'd0,
    SV_IDXRST = 3'd1,
    SV_OFF    = 3'd2,
    SV_HOT    = 3'd3,
    SV_OCP    = 3'd4,
    SV_SLEEP  = 3'd5,
    SV_UV     = 3'd6
  } sv_state_e;

  // Priority: supply-low, sleep, overcurrent latch, thermal, enable, reset.
  function automatic sv_state_e pfs_pick_state(
    input logic uv,
    input logic awake,
    input logic oc_any,
    input logic hot,
    input logic disabled,
    input logic rst_req
  );
    sv_state_e s;
    if (uv)            s = SV_UV;
    else if (!awake)   s = SV_SLEEP;
    else if (oc_any)   s = SV_OCP;
    else if (hot)      s = SV_HOT;
    else if (disabled) s = SV_OFF;
    else if (rst_req)  s = SV_IDXRST;
    else               s = SV_RUN;
    return s;
  endfunction

endpackage

// File: rtl/pfs_sync.sv
module pfs_sync #(
  parameter int W = 8,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] chain_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) chain_q[i] <= RST_VAL;
    end else begin
      chain_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) chain_q[i] <= chain_q[i-1];
    end
  end

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/pfs_oc_qual.sv
module pfs_oc_qual #(
  parameter int OC_QUAL = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic flag_i,
  input  logic gate_i,
  input  logic clear_i,
  output logic latched_o
);

  localparam int CW = (OC_QUAL > 1) ? $clog2(OC_QUAL + 1) : 1;
  localparam logic [CW-1:0] LAST = CW'(OC_QUAL - 1);

  logic [CW-1:0] run_q;
  logic          lat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
      lat_q <= 1'b0;
    end else if (clear_i) begin
      run_q <= '0;
      lat_q <= 1'b0;
    end else if (!gate_i || !flag_i || lat_q) begin
      run_q <= '0;
    end else if (run_q == LAST) begin
      run_q <= '0;
      lat_q <= 1'b1;
    end else begin
      run_q <= run_q + 1'b1;
    end
  end

  assign latched_o = lat_q;

  // R2: a latch only forms at the end of a full qualification run
  p_latch_needs_run_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lat_q) |-> ($past(run_q) == LAST && $past(flag_i) && $past(gate_i)));

  // R3: once latched it stays until cleared
  p_latch_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (lat_q && !clear_i) |=> lat_q);

endmodule

// File: rtl/pfs_wake_timer.sv
module pfs_wake_timer #(
  parameter int WAKE_CYCLES = 250000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold_i,
  output logic done_o
);

  localparam int TW = $clog2(WAKE_CYCLES + 1);
  localparam logic [TW-1:0] TOP = TW'(WAKE_CYCLES);

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (hold_i)        cnt_q <= '0;
    else if (cnt_q != TOP)  cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = (cnt_q == TOP);

  // R8: a held timer is never reported done on the next cycle
  p_wake_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    hold_i |=> !done_o);

endmodule

// File: rtl/power_fault_supervisor.sv
module power_fault_supervisor #(
  parameter int NUM_BRIDGES = 2,
  parameter int SYNC_STAGES = 2,
  parameter int OC_QUAL     = 16,
  parameter int WAKE_CYCLES = 250000
) (
  input  logic                   clk,
  input  logic                   por_n,
  input  logic                   uv_flag,
  input  logic                   hot_flag,
  input  logic [NUM_BRIDGES-1:0] oc_flag,
  input  logic                   sleep_n,
  input  logic                   reset_n,
  input  logic                   enable_n,
  output logic                   bridge_off,
  output logic                   indexer_rst,
  output logic                   fault_n,
  output logic                   step_ok
);
  import pfs_pkg::*;

  localparam int SW = NUM_BRIDGES + 5;
  localparam logic [SW-1:0] SYNC_RST = SW'(16);

  logic [SW-1:0]          raw_vec, syn_vec;
  logic                   uv_s, hot_s, awake_s, rst_ns, dis_s;
  logic [NUM_BRIDGES-1:0] oc_s, oc_lat;
  logic                   oc_any, oc_clear, wake_done;
  sv_state_e              state;

  assign raw_vec = {oc_flag, enable_n, reset_n, sleep_n, hot_flag, uv_flag};

  pfs_sync #(.W(SW), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
    .clk(clk), .rst_n(por_n), .d_i(raw_vec), .q_o(syn_vec)
  );

  assign uv_s    = syn_vec[0];
  assign hot_s   = syn_vec[1];
  assign awake_s = syn_vec[2];
  assign rst_ns  = syn_vec[3];
  assign dis_s   = syn_vec[4];
  assign oc_s    = syn_vec[5 +: NUM_BRIDGES];

  assign oc_clear = uv_s || (awake_s && !rst_ns);

  for (genvar b = 0; b < NUM_BRIDGES; b++) begin : g_oc
    pfs_oc_qual #(.OC_QUAL(OC_QUAL)) u_qual (
      .clk(clk), .rst_n(por_n), .flag_i(oc_s[b]), .gate_i(awake_s),
      .clear_i(oc_clear), .latched_o(oc_lat[b])
    );
  end

  assign oc_any = |oc_lat;

  pfs_wake_timer #(.WAKE_CYCLES(WAKE_CYCLES)) u_wake (
    .clk(clk), .rst_n(por_n), .hold_i(uv_s || !awake_s), .done_o(wake_done)
  );

  always_comb begin
    state = pfs_pick_state(uv_s, awake_s, oc_any, hot_s, dis_s, !rst_ns);
  end

  assign bridge_off  = (state != SV_RUN);
  assign indexer_rst = (state == SV_UV) || (state != SV_SLEEP && !rst_ns);
  assign fault_n     = !((state != SV_UV && state != SV_SLEEP) && (oc_any || hot_s));
  assign step_ok     = (state == SV_RUN) && wake_done;

  // R6: supply-low overrides everything
  p_uv_off_r6: assert property (@(posedge clk) disable iff (!por_n)
    uv_s |-> (bridge_off && indexer_rst && fault_n && !step_ok));

  // R7: sleep quiets the block
  p_sleep_quiet_r7: assert property (@(posedge clk) disable iff (!por_n)
    (!awake_s && !uv_s) |-> (bridge_off && !step_ok && fault_n && !indexer_rst));

  // R8: steps only after settling
  p_step_needs_wake_r8: assert property (@(posedge clk) disable iff (!por_n)
    step_ok |-> wake_done);

  // R3: a latched overcurrent is reported while awake
  p_fault_oc_r3: assert property (@(posedge clk) disable iff (!por_n)
    (oc_any && awake_s && !uv_s) |-> (!fault_n && bridge_off));

  // R5: heat is reported and stops the bridges
  p_hot_r5: assert property (@(posedge clk) disable iff (!por_n)
    (hot_s && awake_s && !uv_s) |-> (!fault_n && bridge_off));

  // R10: reset request drives the indexer home
  p_reset_idx_r10: assert property (@(posedge clk) disable iff (!por_n)
    (awake_s && !rst_ns) |-> (indexer_rst && bridge_off && !step_ok));

endmodule

// File: tb/power_fault_supervisor_bench.sv
module power_fault_supervisor_bench;

  localparam int NB = 2;
  localparam int SY = 2;
  localparam int QL = 4;
  localparam int WK = 6;

  logic clk = 1'b0;
  logic por_n, uv_flag, hot_flag, sleep_n, reset_n, enable_n;
  logic [NB-1:0] oc_flag;
  logic bridge_off, indexer_rst, fault_n, step_ok;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  power_fault_supervisor #(.NUM_BRIDGES(NB), .SYNC_STAGES(SY),
                           .OC_QUAL(QL), .WAKE_CYCLES(WK)) u_power_fault_supervisor (
    .clk(clk), .por_n(por_n), .uv_flag(uv_flag), .hot_flag(hot_flag),
    .oc_flag(oc_flag), .sleep_n(sleep_n), .reset_n(reset_n), .enable_n(enable_n),
    .bridge_off(bridge_off), .indexer_rst(indexer_rst), .fault_n(fault_n),
    .step_ok(step_ok)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input logic act, input logic exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%b expected=%b", what, act, exp);
    end
  endtask

  task automatic report;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=hung expected=finished");
      report();
    end
  end

  initial begin
    por_n = 1'b0; uv_flag = 1'b0; hot_flag = 1'b0; oc_flag = '0;
    sleep_n = 1'b1; reset_n = 1'b1; enable_n = 1'b0;
    tick(3);
    por_n = 1'b1;
    #1;
    chk(fault_n, 1'b1, "R1 fault_n after por");
    chk(bridge_off, 1'b1, "R1 bridge_off after por");
    chk(step_ok, 1'b0, "R1 step_ok after por");
    tick(SY + WK - 1);
    chk(step_ok, 1'b0, "R1 R8 step_ok one cycle before settle");
    tick(1);
    chk(step_ok, 1'b1, "R1 R8 step_ok at settle");
    chk(bridge_off, 1'b0, "R1 bridge on in run");

    // R9 / R12: enable
    enable_n = 1'b1;
    tick(SY - 1);
    chk(step_ok, 1'b1, "R12 enable not yet seen");
    tick(1);
    chk(bridge_off, 1'b1, "R9 bridge_off on disable");
    chk(step_ok, 1'b0, "R9 step_ok on disable");
    chk(indexer_rst, 1'b0, "R9 indexer_rst unaffected");
    chk(fault_n, 1'b1, "R9 fault_n unaffected");
    enable_n = 1'b0;
    tick(SY);
    chk(step_ok, 1'b1, "R9 step_ok after re-enable");

    // R2: pulse-length sweep on each bridge
    for (int b = 0; b < NB; b++) begin
      for (int p = 1; p < QL; p++) begin
        oc_flag[b] = 1'b1;
        tick(p);
        oc_flag[b] = 1'b0;
        tick(SY + 2);
        chk(fault_n, 1'b1, $sformatf("R2 short pulse b%0d len %0d ignored", b, p));
      end
    end

    // R2: exact latch edge on bridge 0
    oc_flag[0] = 1'b1;
    tick(SY + QL - 1);
    chk(fault_n, 1'b1, "R2 one cycle before latch");
    tick(1);
    chk(fault_n, 1'b0, "R2 latch edge");
    oc_flag[0] = 1'b0;
    tick(SY + 2);
    chk(fault_n, 1'b0, "R3 fault held after flag drops");
    chk(bridge_off, 1'b1, "R3 bridge_off held");
    chk(step_ok, 1'b0, "R3 step_ok held low");

    // R4 / R10: reset clears latch
    reset_n = 1'b0;
    tick(SY);
    chk(indexer_rst, 1'b1, "R10 indexer_rst on reset");
    chk(bridge_off, 1'b1, "R10 bridge_off on reset");
    tick(1);
    chk(fault_n, 1'b1, "R4 reset clears latch");
    reset_n = 1'b1;
    tick(SY);
    chk(indexer_rst, 1'b0, "R10 indexer_rst released");
    chk(step_ok, 1'b1, "R10 step_ok after reset");

    // R5: thermal
    hot_flag = 1'b1;
    tick(SY);
    chk(fault_n, 1'b0, "R5 fault on heat");
    chk(bridge_off, 1'b1, "R5 bridge_off on heat");
    hot_flag = 1'b0;
    tick(SY);
    chk(fault_n, 1'b1, "R5 fault self-clears");
    chk(step_ok, 1'b1, "R5 step_ok resumes");

    // R7 / R4: latch on bridge 1, then sleep with ignored stimuli
    oc_flag[1] = 1'b1;
    tick(SY + QL + 1);
    oc_flag[1] = 1'b0;
    tick(SY);
    chk(fault_n, 1'b0, "R2 latch on bridge 1");
    sleep_n = 1'b0;
    tick(SY);
    chk(fault_n, 1'b1, "R7 fault hidden in sleep");
    chk(bridge_off, 1'b1, "R7 bridge_off in sleep");
    chk(step_ok, 1'b0, "R7 step_ok in sleep");
    reset_n = 1'b0;
    enable_n = 1'b1;
    oc_flag[0] = 1'b1;
    tick(SY + QL + 2);
    chk(indexer_rst, 1'b0, "R7 reset ignored in sleep");
    reset_n = 1'b1;
    enable_n = 1'b0;
    oc_flag[0] = 1'b0;
    tick(SY + 1);
    sleep_n = 1'b1;
    tick(SY);
    chk(fault_n, 1'b0, "R4 latch survives sleep");
    reset_n = 1'b0;
    tick(SY + 1);
    reset_n = 1'b1;
    tick(SY + WK);
    chk(fault_n, 1'b1, "R4 latch cleared after wake");
    chk(step_ok, 1'b1, "R7 run after wake and reset");

    // R8: exact settle window
    sleep_n = 1'b0;
    tick(SY + 2);
    sleep_n = 1'b1;
    tick(SY + WK - 1);
    chk(step_ok, 1'b0, "R8 still settling");
    tick(1);
    chk(step_ok, 1'b1, "R8 settle done");

    // R6 / R11: supply-low with latch, heat and reset
    oc_flag[0] = 1'b1;
    tick(SY + QL + 1);
    oc_flag[0] = 1'b0;
    uv_flag = 1'b1;
    hot_flag = 1'b1;
    tick(SY);
    chk(bridge_off, 1'b1, "R6 bridge_off on uv");
    chk(indexer_rst, 1'b1, "R6 indexer_rst on uv");
    chk(fault_n, 1'b1, "R6 fault_n high on uv");
    chk(step_ok, 1'b0, "R6 step_ok low on uv");
    reset_n = 1'b0;
    tick(SY + 1);
    reset_n = 1'b1;
    tick(SY + 1);
    chk(indexer_rst, 1'b1, "R11 uv survives reset");
    chk(bridge_off, 1'b1, "R11 bridge_off through reset");
    hot_flag = 1'b0;
    uv_flag = 1'b0;
    tick(SY + WK - 1);
    chk(fault_n, 1'b1, "R6 latch cleared by uv");
    chk(step_ok, 1'b0, "R6 settle restarted");
    tick(1);
    chk(step_ok, 1'b1, "R6 settle done after uv");

    done = 1'b1;
    report();
  end

endmodule